// File: doc/BRIEF.md
# Device Address Page-Table Translator

This block turns a 32-bit device virtual address into a physical address by looking up one entry in a single-level page table held in memory. A requester presents the address together with the table base register and the window start value taken from the surrounding register block. The block works out where the entry sits, reads that one 32-bit word over a valid/ready memory port, and returns the physical address with a one-cycle done pulse.

The window start bits are first cleared from the request address. The remaining page index, scaled to a word offset, is added to the base register shifted left by four to form the entry address. The fetched entry supplies physical address bits [30:12] from its bits [26:8]. The in-page offset passes through unchanged. Along with the address, the block reports the entry's valid and writable flags and raises an invalid flag when the entry is not valid. It does not cache entries, so every request makes exactly one memory read.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `mem_valid`=0, `done`=0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both 1. While a translation is in progress `req_ready` is 0, and a `req_valid` seen then has no effect.
- R3: The entry read address is `(base_reg << 4) + (((vaddr & ~win_start) >> 10) & ~3)`, computed modulo 2^32.
- R4: `mem_valid` rises the cycle after acceptance. It holds `mem_valid` and `mem_addr` steady until a cycle in which `mem_ready` is 1, then drops in the next cycle.
- R5: Response data is taken only on a `rsp_valid` strobe after the read has been granted. A `rsp_valid` at any other time is ignored.
- R6: The physical address is `((entry & 32'h07FF_FF00) << 4) + (vaddr & 32'hFFF)`.
- R7: `done` is a one-cycle pulse in the cycle after the accepted `rsp_valid`. The block returns to idle (`req_ready`=1) in the same cycle as `done`.
- R8: `pte_valid` is entry bit 1 and `pte_write` is entry bit 2. `fault` is 1 exactly when entry bit 1 is 0. All of these are valid while `done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block idle, can accept a request |
| req_vaddr | input | 32 | Device virtual address |
| base_reg | input | 32 | Page-table base register value |
| win_start | input | 32 | Window start address |
| mem_valid | output | 1 | Entry read request valid |
| mem_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Entry read address |
| rsp_valid | input | 1 | Read data strobe |
| rsp_data | input | 32 | Read data (page-table entry) |
| done | output | 1 | Result pulse |
| phys_addr | output | 32 | Translated physical address |
| pte_valid | output | 1 | Entry valid bit |
| pte_write | output | 1 | Entry writable bit |
| fault | output | 1 | Entry was not valid |

## Verification
The hardest cases to create are the stray strobes. One is a `req_valid` that arrives while a read is still waiting for `mem_ready`. Another is a `rsp_valid` that pulses before the read has been granted. Both must leave the result untouched. The bench stalls `mem_ready` for a random number of cycles and injects both strobes during that stall. It then checks that the eventual result still matches the address latched at acceptance and the correct entry. Random base and window values, including all-ones windows and base values near the top of the range, exercise wraparound of the entry address.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int AW       = 32;
  localparam int PG_SHIFT = 12;
  localparam logic [AW-1:0] PPN_MASK = 32'h07FF_FF00;
  localparam int BIT_VALID = 1;
  localparam int BIT_WRITE = 2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_WAIT = 2'd2} xl_state_e;

  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] base,
                                               input logic [AW-1:0] va,
                                               input logic [AW-1:0] win);
    logic [AW-1:0] rel;
    rel = va & ~win;
    return (base << 4) + ((rel >> (PG_SHIFT - 2)) & ~32'd3);
  endfunction

  function automatic logic [AW-1:0] phys_of(input logic [AW-1:0] pte,
                                            input logic [AW-1:0] va);
    return ((pte & PPN_MASK) << 4) + (va & ((32'd1 << PG_SHIFT) - 1));
  endfunction
endpackage

// File: rtl/dvma_ctrl.sv
module dvma_ctrl
  import dvma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_ready,
  input  logic rsp_valid,
  output logic accept,
  output logic grant,
  output logic capture,
  output logic req_ready,
  output logic mem_valid,
  output logic done
);
  xl_state_e st, st_nx;
  logic done_q;

  assign req_ready = (st == ST_IDLE);
  assign mem_valid = (st == ST_FETCH);
  assign accept    = req_valid && req_ready;
  assign grant     = mem_valid && mem_ready;
  assign capture   = (st == ST_WAIT) && rsp_valid;
  assign done      = done_q;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (accept)  st_nx = ST_FETCH;
      ST_FETCH: if (grant)   st_nx = ST_WAIT;
      ST_WAIT:  if (capture) st_nx = ST_IDLE;
      default:               st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= capture;
    end
  end

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || st == ST_WAIT) |-> !req_ready);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: rtl/dvma_datapath.sv
module dvma_datapath
  import dvma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] win_start,
  input  logic [AW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] phys_addr,
  output logic          pte_valid,
  output logic          pte_write,
  output logic          fault
);
  logic [AW-1:0] va_q, ea_q, pa_q;
  logic v_q, w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q <= '0;
      ea_q <= '0;
      pa_q <= '0;
      v_q  <= 1'b0;
      w_q  <= 1'b0;
    end else begin
      if (accept) begin
        va_q <= req_vaddr;
        ea_q <= entry_addr(base_reg, req_vaddr, win_start);
      end
      if (capture) begin
        pa_q <= phys_of(rsp_data, va_q);
        v_q  <= rsp_data[BIT_VALID];
        w_q  <= rsp_data[BIT_WRITE];
      end
    end
  end

  assign mem_addr  = ea_q;
  assign phys_addr = pa_q;
  assign pte_valid = v_q;
  assign pte_write = w_q;
  assign fault     = ~v_q;

  // R6
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (phys_addr[PG_SHIFT-1:0] == va_q[PG_SHIFT-1:0]));
  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mem_addr));
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] base_reg,
  input  logic [31:0] win_start,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  output logic        done,
  output logic [31:0] phys_addr,
  output logic        pte_valid,
  output logic        pte_write,
  output logic        fault
);
  logic accept, grant, capture;

  dvma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_ready(mem_ready),
    .rsp_valid(rsp_valid), .accept(accept), .grant(grant), .capture(capture),
    .req_ready(req_ready), .mem_valid(mem_valid), .done(done)
  );

  dvma_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_vaddr(req_vaddr), .base_reg(base_reg), .win_start(win_start),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .phys_addr(phys_addr),
    .pte_valid(pte_valid), .pte_write(pte_write), .fault(fault)
  );

  // R8
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == !pte_valid));
  // R4
  mem_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_valid);
  // R5
  grant_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !done);
endmodule

// File: tb/dvma_xlate_tb_top.sv
module dvma_xlate_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, mem_ready = 0, rsp_valid = 0;
  logic [31:0] req_vaddr = 0, base_reg = 0, win_start = 0, rsp_data = 0;
  logic req_ready, mem_valid, done, pte_valid, pte_write, fault;
  logic [31:0] mem_addr, phys_addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dvma_xlate dut_i (.*);

  function automatic logic [31:0] exp_ea(logic [31:0] b, logic [31:0] v, logic [31:0] w);
    logic [31:0] idx;
    idx = (v & ~w) / 1024;
    idx[1:0] = 2'b00;
    return b * 16 + idx;
  endfunction

  function automatic logic [31:0] exp_pa(logic [31:0] e, logic [31:0] v);
    return {1'b0, e[26:8], v[11:0]};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // one translation; stall cycles before grant, optional stray strobes
  task automatic xlate(logic [31:0] va, logic [31:0] b, logic [31:0] w,
                       logic [31:0] e, int stall, bit stray);
    logic [31:0] ea;
    ea = exp_ea(b, va, w);
    @(negedge clk);
    chk("R1/R2 ready", {31'b0, req_ready}, 1);
    req_vaddr = va; base_reg = b; win_start = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    req_vaddr = ~va; base_reg = ~b;
    chk("R4 mem_valid", {31'b0, mem_valid}, 1);
    chk("R3 mem_addr", mem_addr, ea);
    chk("R2 busy", {31'b0, req_ready}, 0);
    for (int i = 0; i < stall; i++) begin
      if (stray) begin req_valid = 1; rsp_valid = 1; rsp_data = 32'h0; end
      @(negedge clk);
      req_valid = 0; rsp_valid = 0;
      chk("R4 hold valid", {31'b0, mem_valid}, 1);
      chk("R4 hold addr", mem_addr, ea);
      chk("R5 no done", {31'b0, done}, 0);
    end
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    chk("R4 drop", {31'b0, mem_valid}, 0);
    repeat (stall % 3) begin
      @(negedge clk);
      chk("R7 no early done", {31'b0, done}, 0);
    end
    rsp_valid = 1; rsp_data = e;
    @(negedge clk);
    rsp_valid = 0; rsp_data = 32'hDEAD_BEEF;
    chk("R7 done", {31'b0, done}, 1);
    chk("R7 idle", {31'b0, req_ready}, 1);
    chk("R6 phys", phys_addr, exp_pa(e, va));
    chk("R8 valid", {31'b0, pte_valid}, {31'b0, e[1]});
    chk("R8 write", {31'b0, pte_write}, {31'b0, e[2]});
    chk("R8 fault", {31'b0, fault}, {31'b0, ~e[1]});
    @(negedge clk);
    chk("R7 pulse", {31'b0, done}, 0);
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready", {31'b0, req_ready}, 1);
        chk("R1 mem_valid", {31'b0, mem_valid}, 0);
        chk("R1 done", {31'b0, done}, 0);
        // stray response while idle
        rsp_valid = 1; rsp_data = 32'hFFFF_FFFF;
        @(negedge clk); rsp_valid = 0;
        chk("R5 idle rsp ignored", {31'b0, done}, 0);
        xlate(32'hFF00_1ABC, 32'h0012_3400, 32'hFF00_0000, 32'h0123_4506, 0, 0);
        xlate(32'h8765_4321, 32'hFFFF_FFFF, 32'h8000_0000, 32'h07FF_FF00, 4, 1);
        xlate(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 1);
        xlate(32'h0, 32'h0, 32'h0, 32'h0000_0084, 1, 0);
        for (int n = 0; n < 40; n++)
          xlate($urandom, $urandom, {$urandom_range(0, 8) == 0 ? 32'h0 : ~((32'd1 << $urandom_range(24, 31)) - 1)},
                $urandom, $urandom_range(0, 5), $urandom_range(0, 1) == 1);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule